// File: doc/BRIEF.md
# Sliding Quadrature Frequency Correlator

This block decides whether a stream of signed samples carries one chosen frequency. It accepts one sample per clock and correlates the last N samples against one period of a sine table and one period of a cosine table. The tables are written once through a small write port, and reset leaves them in place. From the two correlation sums it forms a phase-independent power value. It raises a detect flag while that power exceeds a threshold given at an input.

The window sums are updated recursively. Because the reference repeats every N samples, each new sample adds `ref(n)·(x(n) − x(n−N))` to each sum. Each lane therefore needs one multiplier and one adder whatever N is, plus an N-deep delay line. The datapath has two pipeline stages. Stage one registers the current reference pair and the sample difference. Stage two updates the sums.

Top module: `qcorr_top`

## Requirements
- R1: While reset is held, and in the cycles after it until the first sample result, `out_valid`, `detect`, `m_sin`, `m_cos` and `metric` are all zero.
- R2: A write with `ref_we` high at an address below N stores `ref_sin_d` and `ref_cos_d` into entry `ref_addr`. A write at an address of N or more changes no entry.
- R3: With samples numbered n = 0, 1, … from reset and x(n) taken as 0 for n < 0, `m_sin` after sample n equals the sum over k = 0…N−1 of sin[(n−k) mod N]·x(n−k).
- R4: `m_cos` after sample n equals the same window sum taken with the cosine table.
- R5: A sample accepted at clock edge k changes `m_sin` and `m_cos` only after edge k+1, so the outputs are unchanged in the cycle between those two edges.
- R6: A cycle with `in_valid` low changes neither the sums, nor the reference index, nor the delay line. The next valid sample continues the sequence as if the idle cycle had not occurred.
- R7: `out_valid` rises together with the result of sample N−1, the N-th sample after reset. It then stays high until the next reset.
- R8: `metric` equals m_sin² + m_cos² as an unsigned value, and it follows the sums within the same cycle.
- R9: `detect` is high exactly when `out_valid` is high and `metric` is strictly greater than `thresh`. A change of `thresh` takes effect in the same cycle.
- R10: A tone at the reference frequency gives a peak `metric` more than 16 times the peak given by an equal-amplitude tone at twice that frequency.
- R11: Reset clears the sums, the delay line, the index and the sample count, but keeps the reference tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | DW | Signed input sample |
| ref_we | input | 1 | Reference table write enable |
| ref_addr | input | clog2(N) | Table entry to write |
| ref_sin_d | input | CW | Signed sine value to store |
| ref_cos_d | input | CW | Signed cosine value to store |
| thresh | input | 2·ACCW | Unsigned detection threshold |
| out_valid | output | 1 | High once a full window has been summed |
| m_sin | output | ACCW | Signed sine correlation sum |
| m_cos | output | ACCW | Signed cosine correlation sum |
| metric | output | 2·ACCW | Unsigned m_sin² + m_cos² |
| detect | output | 1 | Metric above threshold with a full window |

## Verification
A sample driven before rising edge k is taken into stage one at edge k. Its sums are due after edge k+1, and `metric` and `detect` follow combinationally in that same cycle. The bench drives on the falling edge and keeps a two-deep queue of expected results. Each falling edge compares the outputs against the entry queued two falling edges earlier, and the latency task checks that nothing has moved one edge after the sample. Threshold checks are made while the inputs are idle, so the sums are steady, and they are sampled a little after `thresh` changes.

// File: rtl/qcorr_pkg.sv
package qcorr_pkg;

  // number of correlation lanes: sine and cosine
  localparam int unsigned NLANES = 2;

  // modulo-n increment used by the reference index
  function automatic int unsigned wrap_next(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/qcorr_ref_table.sv
module qcorr_ref_table #(
  parameter int N  = 5,
  parameter int CW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_sin,
  input  logic signed [CW-1:0] wr_cos,
  input  logic                 adv,
  output logic signed [CW-1:0] cur_sin,
  output logic signed [CW-1:0] cur_cos
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic signed [CW-1:0] sin_mem [N];
  logic signed [CW-1:0] cos_mem [N];
  logic [IW-1:0]        idx;
  logic                 wr_hit;

  assign wr_hit = wr_en && (wr_addr <= LAST);

  // tables survive reset: loaded once, read many times
  always_ff @(posedge clk) begin
    if (wr_hit) begin
      sin_mem[wr_addr] <= wr_sin;
      cos_mem[wr_addr] <= wr_cos;
    end
  end

  // index into one period, plus the stage-one reference registers
  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      cur_sin <= '0;
      cur_cos <= '0;
    end else if (adv) begin
      idx     <= IW'(qcorr_pkg::wrap_next(32'(idx), N));
      cur_sin <= sin_mem[idx];
      cur_cos <= cos_mem[idx];
    end
  end

  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst) idx <= LAST);
  p_idx_wrap_r3:  assert property (@(posedge clk) disable iff (rst)
                    (adv && idx == LAST) |=> idx == '0);
  p_idx_hold_r6:  assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(idx));

endmodule

// File: rtl/qcorr_delay.sv
module qcorr_delay #(
  parameter int N  = 5,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW:0]   diff,
  output logic                 diff_valid
);
  logic signed [DW-1:0] line [N];

  // newest sample enters stage 0, x(n-N) sits in stage N-1
  always_ff @(posedge clk) begin
    if (rst)      line[0] <= '0;
    else if (adv) line[0] <= x_in;
  end

  for (genvar g = 1; g < N; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)      line[g] <= '0;
      else if (adv) line[g] <= line[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diff       <= '0;
      diff_valid <= 1'b0;
    end else begin
      diff_valid <= adv;
      if (adv) diff <= (DW+1)'(x_in) - (DW+1)'(line[N-1]);
    end
  end

  p_diff_hold_r6: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(diff));
  p_line_hold_r6: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(line[N-1]));

endmodule

// File: rtl/qcorr_mac.sv
module qcorr_mac #(
  parameter int CW   = 12,
  parameter int DW   = 12,
  parameter int ACCW = 28
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [CW-1:0]   coef,
  input  logic signed [DW:0]     diff,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = CW + DW + 1;

  // one recursive window step: acc + coef * (x(n) - x(n-N))
  function automatic logic signed [ACCW-1:0] mac_step(
    input logic signed [ACCW-1:0] a,
    input logic signed [CW-1:0]   c,
    input logic signed [DW:0]     d
  );
    logic signed [PW-1:0] p;
    p = PW'(c) * PW'(d);
    return a + ACCW'(p);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= mac_step(acc, coef, diff);
  end

  p_acc_hold_r6:    assert property (@(posedge clk) disable iff (rst) !en |=> $stable(acc));
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> acc == '0);

endmodule

// File: rtl/qcorr_top.sv
module qcorr_top #(
  parameter int N    = 5,
  parameter int DW   = 12,
  parameter int CW   = 12,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int ACCW = DW + CW + $clog2(N) + 1,
  localparam int MW   = 2 * ACCW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_sample,
  input  logic                   ref_we,
  input  logic [IW-1:0]          ref_addr,
  input  logic signed [CW-1:0]   ref_sin_d,
  input  logic signed [CW-1:0]   ref_cos_d,
  input  logic [MW-1:0]          thresh,
  output logic                   out_valid,
  output logic signed [ACCW-1:0] m_sin,
  output logic signed [ACCW-1:0] m_cos,
  output logic [MW-1:0]          metric,
  output logic                   detect
);
  localparam int CNTW = $clog2(N + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(N);

  logic signed [CW-1:0]   lane_ref [qcorr_pkg::NLANES];
  logic signed [ACCW-1:0] lane_acc [qcorr_pkg::NLANES];
  logic signed [DW:0]     s1_diff;
  logic                   s1_valid;
  logic [CNTW-1:0]        fill;

  // power of the quadrature pair, independent of input phase
  function automatic logic [MW-1:0] power(
    input logic signed [ACCW-1:0] a,
    input logic signed [ACCW-1:0] b
  );
    logic signed [MW-1:0] sa;
    logic signed [MW-1:0] sb;
    sa = MW'(a);
    sb = MW'(b);
    return MW'(sa * sa + sb * sb);
  endfunction

  qcorr_ref_table #(.N(N), .CW(CW)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ref_we),
    .wr_addr (ref_addr),
    .wr_sin  (ref_sin_d),
    .wr_cos  (ref_cos_d),
    .adv     (in_valid),
    .cur_sin (lane_ref[0]),
    .cur_cos (lane_ref[1])
  );

  qcorr_delay #(.N(N), .DW(DW)) u_dly (
    .clk        (clk),
    .rst        (rst),
    .adv        (in_valid),
    .x_in       (in_sample),
    .diff       (s1_diff),
    .diff_valid (s1_valid)
  );

  for (genvar l = 0; l < qcorr_pkg::NLANES; l++) begin : g_lane
    qcorr_mac #(.CW(CW), .DW(DW), .ACCW(ACCW)) u_mac (
      .clk  (clk),
      .rst  (rst),
      .en   (s1_valid),
      .coef (lane_ref[l]),
      .diff (s1_diff),
      .acc  (lane_acc[l])
    );
  end

  // count samples summed until the window is full
  always_ff @(posedge clk) begin
    if (rst)                          fill <= '0;
    else if (s1_valid && fill != FULL) fill <= fill + 1'b1;
  end

  assign out_valid = (fill == FULL);
  assign m_sin     = lane_acc[0];
  assign m_cos     = lane_acc[1];
  assign metric    = power(lane_acc[0], lane_acc[1]);
  assign detect    = out_valid && (metric > thresh);

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst) out_valid |=> out_valid);
  p_first_valid_r7:  assert property (@(posedge clk) disable iff (rst)
                       $rose(out_valid) |-> $past(s1_valid));
  p_idle_metric_r6:  assert property (@(posedge clk) disable iff (rst)
                       !s1_valid |=> $stable(metric));

endmodule

// File: tb/tb_qcorr_top.sv
`timescale 1ns/1ps
module tb_qcorr_top;
  localparam int N    = 5;
  localparam int DW   = 12;
  localparam int CW   = 12;
  localparam int ACCW = DW + CW + $clog2(N) + 1;
  localparam int MW   = 2 * ACCW;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic ref_we = 1'b0;
  logic [2:0] ref_addr = '0;
  logic signed [CW-1:0] ref_sin_d = '0;
  logic signed [CW-1:0] ref_cos_d = '0;
  logic [MW-1:0] thresh = '1;
  logic out_valid;
  logic signed [ACCW-1:0] m_sin;
  logic signed [ACCW-1:0] m_cos;
  logic [MW-1:0] metric;
  logic detect;

  qcorr_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .ref_we(ref_we), .ref_addr(ref_addr), .ref_sin_d(ref_sin_d), .ref_cos_d(ref_cos_d),
    .thresh(thresh), .out_valid(out_valid), .m_sin(m_sin), .m_cos(m_cos),
    .metric(metric), .detect(detect)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int sin_tab [N];
  int cos_tab [N];
  longint hist [N];
  int mod_n;
  longint mod_m1, mod_m2;
  longint q0_m1, q0_m2, q1_m1, q1_m2;
  bit q0_ov, q1_ov;
  longint peak;

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic model_clear();
    for (int j = 0; j < N; j++) hist[j] = 0;
    mod_n = 0; mod_m1 = 0; mod_m2 = 0;
    q0_m1 = 0; q0_m2 = 0; q1_m1 = 0; q1_m2 = 0; q0_ov = 0; q1_ov = 0;
  endtask

  // direct window sum, not the recursion
  task automatic model_push(input int x);
    for (int j = N - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    mod_m1 = 0; mod_m2 = 0;
    for (int j = 0; j < N; j++) begin
      if (mod_n - j >= 0) begin
        mod_m1 += longint'(sin_tab[(mod_n - j) % N]) * hist[j];
        mod_m2 += longint'(cos_tab[(mod_n - j) % N]) * hist[j];
      end
    end
    mod_n++;
  endtask

  task automatic check_all(input string sc, input longint e1, input longint e2, input bit eov);
    longint em;
    em = e1 * e1 + e2 * e2;
    chk({sc, " R3 m_sin"}, longint'(m_sin), e1);
    chk({sc, " R4 m_cos"}, longint'(m_cos), e2);
    chk({sc, " R8 metric"}, longint'(metric), em);
    chk({sc, " R7 out_valid"}, longint'(out_valid), longint'(eov));
    chk({sc, " R9 detect"}, longint'(detect), longint'(eov && (em > longint'(thresh))));
    if (out_valid && longint'(metric) > peak) peak = longint'(metric);
  endtask

  // drive one cycle; check the result queued two falling edges ago
  task automatic step(input bit v, input int x, input string sc);
    @(negedge clk);
    check_all(sc, q1_m1, q1_m2, q1_ov);
    q1_m1 = q0_m1; q1_m2 = q0_m2; q1_ov = q0_ov;
    if (v) model_push(x);
    q0_m1 = mod_m1; q0_m2 = mod_m2; q0_ov = (mod_n >= N);
    in_valid = v;
    in_sample = DW'(x);
  endtask

  task automatic flush(input string sc);
    step(1'b0, 0, sc);
    step(1'b0, 0, sc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    peak = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check_all("R1 reset", 0, 0, 0);
    chk("R1 metric zero", longint'(metric), 0);
  endtask

  task automatic t_load_table();
    for (int k = 0; k < N; k++) begin
      sin_tab[k] = rnd(2047.0 * $sin(2.0 * PI * k / N));
      cos_tab[k] = rnd(2047.0 * $cos(2.0 * PI * k / N));
      @(negedge clk);
      ref_we = 1'b1; ref_addr = 3'(k);
      ref_sin_d = CW'(sin_tab[k]); ref_cos_d = CW'(cos_tab[k]);
    end
    for (int k = N; k < 8; k++) begin
      @(negedge clk);
      ref_we = 1'b1; ref_addr = 3'(k);
      ref_sin_d = 12'sh7ff; ref_cos_d = -12'sh7ff;
    end
    @(negedge clk);
    ref_we = 1'b0;
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1000 - 300 * i, "R2 table");
    flush("R2 table");
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_sample = 12'sd700;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 m_cos one edge", longint'(m_cos), 0);
    chk("R5 m_sin one edge", longint'(m_sin), 0);
    @(negedge clk);
    chk("R5 m_cos two edges", longint'(m_cos), longint'(cos_tab[0]) * 700);
  endtask

  task automatic t_match();
    do_reset();
    thresh = 56'd20000000000000;
    for (int i = 0; i < 15; i++)
      step(1'b1, rnd(1500.0 * $sin(2.0 * PI * i / N + 0.7)), "R3R4 match");
    flush("R3R4 match");
    thresh = '1;
  endtask

  task automatic t_gap();
    do_reset();
    for (int i = 0; i < 24; i++)
      step((i % 3) != 1, int'($urandom_range(4000)) - 2000, "R6 gap");
    flush("R6 gap");
  endtask

  task automatic t_thresh();
    longint m;
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, rnd(1800.0 * $cos(2.0 * PI * i / N)), "R9 feed");
    flush("R9 feed");
    m = q1_m1 * q1_m1 + q1_m2 * q1_m2;
    @(negedge clk);
    thresh = MW'(m);
    #1 chk("R9 equal thresh", longint'(detect), 0);
    thresh = MW'(m - 1);
    #1 chk("R9 thresh below", longint'(detect), 1);
    thresh = '1;
    #1 chk("R9 max thresh", longint'(detect), 0);
  endtask

  task automatic t_select();
    longint pk_on, pk_off;
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, rnd(1500.0 * $sin(2.0 * PI * i / N)), "R10 on");
    flush("R10 on");
    pk_on = peak;
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, rnd(1500.0 * $sin(4.0 * PI * i / N)), "R10 off");
    flush("R10 off");
    pk_off = peak;
    chk("R10 peak ratio", longint'(pk_on > 16 * pk_off), 1);
  endtask

  task automatic t_mid_reset();
    do_reset();
    for (int i = 0; i < 7; i++) step(1'b1, 1900 - 500 * i, "R11 pre");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 m_sin cleared", longint'(m_sin), 0);
    chk("R11 m_cos cleared", longint'(m_cos), 0);
    chk("R11 out_valid cleared", longint'(out_valid), 0);
    model_clear();
    for (int i = 0; i < 9; i++) step(1'b1, int'($urandom_range(4000)) - 2000, "R11 post");
    flush("R11 post");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    peak = 0;
    t_reset_state();
    t_load_table();
    t_latency();
    t_match();
    t_gap();
    t_thresh();
    t_select();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule